// File: doc/BRIEF.md
# Two-Stage APB Watchdog Timer

This block is a watchdog peripheral that sits on an APB bus. It has a reloadable down-counter, and the counter decrements only on cycles where a count-enable tick is high. When the counter expires for the first time, the block flags an interrupt and reloads the counter. If software has not acknowledged that interrupt by the time the counter expires again, the block raises a reset request and halts the counter.

Software services the watchdog by writing the interrupt-clear register. That write drops the pending interrupt and restarts the countdown from the load value. A write lock guards the configuration: every write except to the lock register is dropped until a fixed key has been written. A test mode lets software drive both outputs directly. Fixed identification bytes are readable at the top of the 4 KiB window.

Top module: `apb_wdt`

## Requirements
- R1: Every APB transfer completes with zero wait states, with `pready_o` held 1 and `pslverr_o` held 0. Only the word address `paddr_i[11:2]` is decoded.
- R1 (register map, as byte offsets): LOAD 0x000, VALUE 0x004 (current count, read-only), CONTROL 0x008, INTCLR 0x00C (write-only), RIS 0x010, MIS 0x014, LOCK 0xC00, ITCR 0xF00, ITOP 0xF04 (write-only).
- R2: CONTROL bit 0 is the interrupt enable and bit 1 is the reset enable. All other bits are dropped on write and read back as 0.
- R3: A write to LOAD sets both the reload value and the current count to the written data, and it starts counting.
- R4: On expiry with RIS clear, RIS is set and the count reloads. On expiry with RIS already set, the reset status is set and counting stops.
- R5: Any write to INTCLR clears RIS and sets the count to the reload value.
- R6: `irq_o` = RIS AND CONTROL[0], and `rst_req_o` = reset status AND CONTROL[1]. MIS reads RIS AND CONTROL[0].
- R7: Writing 0x1ACCE551 to LOCK unlocks the block, and any other value locks it. LOCK reads 1 while locked. While locked, writes to every other register are dropped.
- R8: When ITCR bit 0 is 1, `irq_o` follows ITOP bit 1 and `rst_req_o` follows ITOP bit 0.
- R9: After reset, CONTROL, RIS, reset status, LOCK, ITCR and ITOP are 0. LOAD and VALUE are 0xFFFFFFFF, and counting is active.
- R10: The identification bytes read as follows: 0x04,0x00,0x00,0x00 at 0xFD0..0xFDC; 0x24,0xB8,0x1B,0x00 at 0xFE0..0xFEC; 0x0D,0xF0,0x05,0xB1 at 0xFF0..0xFFC.
- R11: Reads of write-only or unmapped offsets return 0. Writes to read-only or unmapped offsets change nothing.
- R12: The count drops by one on each tick while counting. Expiry is the tick seen at count 0. Once halted, the counter stays halted until LOAD is written or the block is reset, and an INTCLR write does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 10 | APB word address, bits 11:2 |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| tick_i | input | 1 | Count enable |
| irq_o | output | 1 | Interrupt output |
| rst_req_o | output | 1 | Reset request output |

## Verification
The hardest state to reach is the second expiry. RIS must still be set at that moment, and the counter must then stay frozen even though ticks keep arriving. The bench gets there by loading a small count, enabling both outputs and pulsing the tick past two full periods. It then keeps ticking and confirms that VALUE holds at 0. After that it shows that an INTCLR write reloads the count without restarting it, and that only a LOAD write revives it. A second run clears the interrupt between the two expiries and confirms that no reset request follows.

// File: rtl/apb_wdt_pkg.sv
package apb_wdt_pkg;
  localparam int unsigned AW = 10;
  localparam logic [AW-1:0] IDX_LOAD  = 10'h000;
  localparam logic [AW-1:0] IDX_VALUE = 10'h001;
  localparam logic [AW-1:0] IDX_CTRL  = 10'h002;
  localparam logic [AW-1:0] IDX_CLR   = 10'h003;
  localparam logic [AW-1:0] IDX_RIS   = 10'h004;
  localparam logic [AW-1:0] IDX_MIS   = 10'h005;
  localparam logic [AW-1:0] IDX_LOCK  = 10'h300;
  localparam logic [AW-1:0] IDX_ITCR  = 10'h3C0;
  localparam logic [AW-1:0] IDX_ITOP  = 10'h3C1;
  localparam logic [AW-1:0] IDX_ID0   = 10'h3F4;
  localparam logic [31:0]   UNLOCK_KEY = 32'h1ACC_E551;

  function automatic logic [7:0] id_byte(input logic [3:0] i);
    case (i)
      4'd0:    return 8'h04;
      4'd4:    return 8'h24;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/apb_wdt_counter.sv
module apb_wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_we_i,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ris_o,
  output logic             rst_stat_o
);
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             run_q, ris_q, rst_q;
  logic             expire;

  assign expire = tick_i && run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '1;
      cnt_q  <= '1;
      run_q  <= 1'b1;
      ris_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else if (load_we_i) begin
      load_q <= load_val_i;
      cnt_q  <= load_val_i;
      run_q  <= 1'b1;
    end else if (clr_we_i) begin
      ris_q <= 1'b0;
      cnt_q <= load_q;
    end else if (expire) begin
      if (!ris_q) begin
        ris_q <= 1'b1;
        cnt_q <= load_q;
      end else begin
        rst_q <= 1'b1;
        run_q <= 1'b0;
      end
    end else if (tick_i && run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign load_o     = load_q;
  assign cnt_o      = cnt_q;
  assign ris_o      = ris_q;
  assign rst_stat_o = rst_q;

  a_r3_load_sets_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> (cnt_q == $past(load_val_i)) && (load_q == $past(load_val_i)) && run_q);
  a_r5_clear_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !load_we_i) |=> !ris_q && (cnt_q == $past(load_q)));
  a_r4_second_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ris_q && !load_we_i && !clr_we_i) |=> rst_q && !run_q);
  a_r12_halted_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_we_i && !clr_we_i) |=> $stable(cnt_q));
  a_r4_reset_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> rst_q);
endmodule

// File: rtl/apb_wdt_regs.sv
module apb_wdt_regs
  import apb_wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psel_i,
  input  logic             penable_i,
  input  logic             pwrite_i,
  input  logic [AW-1:0]    paddr_i,
  input  logic [31:0]      pwdata_i,
  output logic [31:0]      prdata_o,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ris_i,
  output logic             load_we_o,
  output logic             clr_we_o,
  output logic [1:0]       ctrl_o,
  output logic             itcr_o,
  output logic [1:0]       itop_o
);
  logic       wr_en, wr_ok, lock_q, itcr_q;
  logic [1:0] ctrl_q, itop_q;
  logic [AW-1:0] id_off;

  assign wr_en     = psel_i && penable_i && pwrite_i;
  assign wr_ok     = wr_en && !lock_q;
  assign load_we_o = wr_ok && (paddr_i == IDX_LOAD);
  assign clr_we_o  = wr_ok && (paddr_i == IDX_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      itcr_q <= 1'b0;
      itop_q <= '0;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      if (paddr_i == IDX_LOCK) lock_q <= (pwdata_i != UNLOCK_KEY);
      if (!lock_q) begin
        if (paddr_i == IDX_CTRL) ctrl_q <= pwdata_i[1:0];
        if (paddr_i == IDX_ITCR) itcr_q <= pwdata_i[0];
        if (paddr_i == IDX_ITOP) itop_q <= pwdata_i[1:0];
      end
    end
  end

  assign id_off = paddr_i - IDX_ID0;

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      IDX_LOAD:  prdata_o = 32'(load_i);
      IDX_VALUE: prdata_o = 32'(cnt_i);
      IDX_CTRL:  prdata_o = {30'd0, ctrl_q};
      IDX_RIS:   prdata_o = {31'd0, ris_i};
      IDX_MIS:   prdata_o = {31'd0, ris_i & ctrl_q[0]};
      IDX_LOCK:  prdata_o = {31'd0, lock_q};
      IDX_ITCR:  prdata_o = {31'd0, itcr_q};
      default:   if (paddr_i >= IDX_ID0) prdata_o = {24'd0, id_byte(id_off[3:0])};
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign itcr_o = itcr_q;
  assign itop_o = itop_q;

  a_r7_locked_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr_en && paddr_i != IDX_LOCK) |=> $stable(ctrl_q) && $stable(itcr_q) && $stable(itop_q));
  a_r7_key_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && paddr_i == IDX_LOCK && pwdata_i == UNLOCK_KEY) |=> !lock_q);
endmodule

// File: rtl/apb_wdt_outsel.sv
module apb_wdt_outsel (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ris_i,
  input  logic       rst_stat_i,
  input  logic [1:0] ctrl_i,
  input  logic       itcr_i,
  input  logic [1:0] itop_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  logic irq_func, rst_func;

  assign irq_func  = ris_i & ctrl_i[0];
  assign rst_func  = rst_stat_i & ctrl_i[1];
  assign irq_o     = itcr_i ? itop_i[1] : irq_func;
  assign rst_req_o = itcr_i ? itop_i[0] : rst_func;

  a_r8_test_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itcr_i |-> (irq_o == itop_i[1]) && (rst_req_o == itop_i[0]));
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!itcr_i && !ctrl_i[0]) |-> !irq_o);
endmodule

// File: rtl/apb_wdt.sv
module apb_wdt
  import apb_wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        psel_i,
  input  logic        penable_i,
  input  logic        pwrite_i,
  input  logic [11:2] paddr_i,
  input  logic [31:0] pwdata_i,
  output logic [31:0] prdata_o,
  output logic        pready_o,
  output logic        pslverr_o,
  input  logic        tick_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic [CNT_W-1:0] load_w, cnt_w;
  logic ris_w, rst_stat_w, load_we_w, clr_we_w, itcr_w;
  logic [1:0] ctrl_w, itop_w;

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  apb_wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i,
    .paddr_i(paddr_i), .pwdata_i, .prdata_o,
    .load_i(load_w), .cnt_i(cnt_w), .ris_i(ris_w),
    .load_we_o(load_we_w), .clr_we_o(clr_we_w),
    .ctrl_o(ctrl_w), .itcr_o(itcr_w), .itop_o(itop_w)
  );

  apb_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_we_i(load_we_w), .load_val_i(pwdata_i[CNT_W-1:0]), .clr_we_i(clr_we_w),
    .load_o(load_w), .cnt_o(cnt_w), .ris_o(ris_w), .rst_stat_o(rst_stat_w)
  );

  apb_wdt_outsel u_out (
    .clk_i, .rst_ni, .ris_i(ris_w), .rst_stat_i(rst_stat_w),
    .ctrl_i(ctrl_w), .itcr_i(itcr_w), .itop_i(itop_w),
    .irq_o, .rst_req_o
  );

  a_r4_first_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_w == '0 && !ris_w && !rst_stat_w && !load_we_w && !clr_we_w) |=> ris_w && (cnt_w == load_w));
endmodule

// File: tb/tb_apb_wdt.sv
`timescale 1ns/1ps
module tb_apb_wdt;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, tick = 0;
  logic [11:2] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, irq, rst_req;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  apb_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .tick_i(tick), .irq_o(irq), .rst_req_o(rst_req)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'hFFFF_FFFF, 8'd9},  // R9 LOAD reset
    '{1'b0, 12'h008, 32'h0000_0000, 8'd9},  // R9 CONTROL reset
    '{1'b0, 12'hC00, 32'h0000_0000, 8'd9},  // R9 LOCK reset
    '{1'b1, 12'h008, 32'hFFFF_FFFF, 8'd2},
    '{1'b0, 12'h008, 32'h0000_0003, 8'd2},  // R2 only two bits kept
    '{1'b0, 12'hFD0, 32'h0000_0004, 8'd10}, // R10
    '{1'b0, 12'hFE0, 32'h0000_0024, 8'd10},
    '{1'b0, 12'hFE4, 32'h0000_00B8, 8'd10},
    '{1'b0, 12'hFF0, 32'h0000_000D, 8'd10},
    '{1'b0, 12'hFFC, 32'h0000_00B1, 8'd10},
    '{1'b0, 12'h00C, 32'h0000_0000, 8'd11}, // R11 write-only reads 0
    '{1'b0, 12'h100, 32'h0000_0000, 8'd11}, // R11 unmapped
    '{1'b1, 12'h000, 32'h0000_1234, 8'd3},
    '{1'b0, 12'h004, 32'h0000_1234, 8'd3},  // R3 VALUE follows LOAD
    '{1'b1, 12'h004, 32'h0000_0055, 8'd11},
    '{1'b0, 12'h004, 32'h0000_1234, 8'd11}, // R11 VALUE write ignored
    '{1'b1, 12'hC00, 32'h0000_0000, 8'd7},
    '{1'b0, 12'hC00, 32'h0000_0001, 8'd7},  // R7 locked
    '{1'b1, 12'h008, 32'h0000_0000, 8'd7},
    '{1'b0, 12'h008, 32'h0000_0003, 8'd7},  // R7 CONTROL write dropped
    '{1'b1, 12'hC00, 32'h1ACC_E551, 8'd7},
    '{1'b0, 12'hC00, 32'h0000_0000, 8'd7}   // R7 unlocked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a[11:2]; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a[11:2];
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    chk("R1 pready", {31'd0, pready}, 32'd1);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R9 irq", {31'd0, irq}, 0);
    chk("R9 rst_req", {31'd0, rst_req}, 0);
    chk("R1 pslverr", {31'd0, pslverr}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) apb_wr(VECS[i].addr, VECS[i].data);
      else rd_chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
    end

    // Two-stage expiry, halt, clear, restart
    do_reset();
    rd_chk("R9 VALUE", 12'h004, 32'hFFFF_FFFF);
    ticks(1);
    rd_chk("R9 counting", 12'h004, 32'hFFFF_FFFE);
    apb_wr(12'h008, 32'd3);
    apb_wr(12'h000, 32'd3);
    ticks(4);
    rd_chk("R4 first RIS", 12'h010, 32'd1);
    rd_chk("R4 reload", 12'h004, 32'd3);
    rd_chk("R6 MIS", 12'h014, 32'd1);
    chk("R6 irq", {31'd0, irq}, 1);
    chk("R4 no rst yet", {31'd0, rst_req}, 0);
    ticks(4);
    chk("R4 rst_req", {31'd0, rst_req}, 1);
    ticks(3);
    rd_chk("R12 halted", 12'h004, 32'd0);
    apb_wr(12'h00C, 32'd0);
    rd_chk("R5 RIS cleared", 12'h010, 32'd0);
    rd_chk("R5 reload", 12'h004, 32'd3);
    chk("R5 irq low", {31'd0, irq}, 0);
    ticks(2);
    rd_chk("R12 clr no restart", 12'h004, 32'd3);
    apb_wr(12'h000, 32'd10);
    ticks(1);
    rd_chk("R12 LOAD restarts", 12'h004, 32'd9);

    // Service between expiries: no reset
    do_reset();
    apb_wr(12'h008, 32'd3);
    apb_wr(12'h000, 32'd2);
    ticks(3);
    rd_chk("R4 RIS", 12'h010, 32'd1);
    apb_wr(12'h00C, 32'hDEAD_BEEF);
    ticks(3);
    chk("R5 serviced no rst", {31'd0, rst_req}, 0);
    chk("R5 irq again", {31'd0, irq}, 1);
    apb_wr(12'h010, 32'd0);
    rd_chk("R11 RIS write ignored", 12'h010, 32'd1);
    apb_wr(12'h008, 32'd0);
    chk("R6 masked irq", {31'd0, irq}, 0);
    rd_chk("R6 MIS masked", 12'h014, 32'd0);
    rd_chk("R6 RIS raw", 12'h010, 32'd1);

    // Test mode override
    apb_wr(12'hF00, 32'd1);
    apb_wr(12'hF04, 32'd2);
    chk("R8 irq from ITOP", {31'd0, irq}, 1);
    chk("R8 rst from ITOP", {31'd0, rst_req}, 0);
    apb_wr(12'hF04, 32'd1);
    chk("R8 irq low", {31'd0, irq}, 0);
    chk("R8 rst high", {31'd0, rst_req}, 1);
    rd_chk("R11 ITOP reads 0", 12'hF04, 32'd0);
    apb_wr(12'hC00, 32'h1ACC_E550);
    apb_wr(12'hF04, 32'd2);
    chk("R7 locked ITOP", {31'd0, rst_req}, 1);
    apb_wr(12'hC00, 32'h1ACC_E551);
    apb_wr(12'hF00, 32'd0);
    chk("R8 override off irq", {31'd0, irq}, 0);
    chk("R8 override off rst", {31'd0, rst_req}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule